// File: doc/BRIEF.md
# Dual-Issue Slot Pairing Checker

This block sits between instruction decode and the execution units of an in-order core that can send out up to two instructions per cycle. Each cycle it looks at the two oldest decoded instructions. Slot 0 always holds the older one and slot 1 the younger. The block decides whether they leave together as one dispatch group, whether only the older one leaves, or whether nothing leaves. Each slot carries a unit-class tag and flags for non-pipelined, microcoded and context-synchronizing instructions. Slot 0 also carries the word-offset bit of its fetch address. A downstream stall input holds dispatch.

Pairing is refused in these cases:
- both instructions need the same unit class;
- the older instruction must run alone because it is a branch, is non-pipelined, or sits in the upper word of its 8-byte fetch block;
- either instruction is context-synchronizing or microcoded.

A microcoded instruction at the head waits a fixed number of cycles, by default 7, for its first micro-op from the microcode ROM. Once that wait is over it leaves alone. The upstream queue uses the two grant outputs to retire entries. A lone grant on slot 0 means the slot 1 instruction moves into slot 0 on the following cycle. The decision is registered, so grants appear one cycle after the inputs that caused them.

Top module: `dual_issue_pair`

## Requirements
- R1: During and right after synchronous reset, `grant0` and `grant1` are 0 and `ucode_wait` is 0.
- R2: The class codes are 0 fixed-point, 1 load/store, 2 branch, 3 vector arithmetic and 4 vector permute/load-store. When both slots are valid and carry the same code, only slot 0 is granted (`grant0`=1, `grant1`=0).
- R3: If both slots are valid with different classes and no rule below applies, both grants are 1 on the cycle after the inputs are presented.
- R4: If slot 0 is a branch (class 2) or is non-pipelined, slot 0 issues alone. A branch in slot 1 may still pair.
- R5: A context-synchronizing instruction in either slot prevents pairing, and slot 0 issues alone.
- R6: If the slot 0 address word bit is 1 (slot 0 is the upper word of its 8-byte block), slot 0 issues alone.
- R7: A microcoded instruction held in slot 0 produces no grant. `ucode_wait` steps 1, 2, … up to MC_DELAY (7) on successive cycles. On the next cycle `grant0`=1 and `grant1`=0, and `ucode_wait` returns to 0.
- R8: A microcoded instruction in slot 1 only, under slot 0, is not paired. Slot 0 issues alone and `ucode_wait` stays 0.
- R9: While `hold` is 1, neither grant is given. A microcode wait keeps counting and then stays at MC_DELAY, and the head issues on the cycle after `hold` drops.
- R10: Slot 0 valid with slot 1 empty grants slot 0 only. With slot 0 empty, no grant is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_vld | input | 1 | Slot 0 holds an instruction |
| s0_cls | input | 3 | Slot 0 unit class code |
| s0_np | input | 1 | Slot 0 is non-pipelined |
| s0_mc | input | 1 | Slot 0 is microcoded |
| s0_cs | input | 1 | Slot 0 is context-synchronizing |
| s0_hiword | input | 1 | Slot 0 sits in the upper word of its 8-byte block |
| s1_vld | input | 1 | Slot 1 holds an instruction |
| s1_cls | input | 3 | Slot 1 unit class code |
| s1_mc | input | 1 | Slot 1 is microcoded |
| s1_cs | input | 1 | Slot 1 is context-synchronizing |
| hold | input | 1 | Downstream stall, blocks both slots |
| grant0 | output | 1 | Slot 0 dispatched this cycle (registered) |
| grant1 | output | 1 | Slot 1 dispatched together with slot 0 (registered) |
| ucode_wait | output | 3 | Cycles spent waiting on the microcode ROM |

## Verification
The assertions assume three things about the inputs:
- class codes stay within 0 to 4;
- slot 1 is never valid while slot 0 is empty;
- the upstream queue holds a microcoded head steady until it has been granted.

The stimulus keeps to these assumptions. The sweeps draw classes only from the five legal codes and always fill slot 0 before slot 1. Every microcode scenario keeps its inputs constant until the grant appears, then presents a non-microcoded pair so that the wait counter clears before the next scenario.

// File: rtl/dip_pkg.sv
package dip_pkg;
  typedef enum logic [2:0] {
    CL_FX = 3'd0,
    CL_LS = 3'd1,
    CL_BR = 3'd2,
    CL_VA = 3'd3,
    CL_VP = 3'd4
  } ucls_e;

  localparam int NUM_CLS = 5;

  typedef struct packed {
    logic       vld;
    logic [2:0] cls;
    logic       np;
    logic       mc;
    logic       cs;
  } head_slot_t;
endpackage

// File: rtl/dip_pair_rules.sv
module dip_pair_rules
  import dip_pkg::*;
#(
  parameter int NCLS = NUM_CLS
) (
  input  head_slot_t a,
  input  logic       a_hiword,
  input  logic       b_vld,
  input  logic [2:0] b_cls,
  input  logic       b_mc,
  input  logic       b_cs,
  output logic       pair_ok
);
  localparam int TBL = NCLS * NCLS;
  localparam int IW  = $clog2(TBL);

  // unit-class conflict matrix, one bit per ordered class pair
  logic [TBL-1:0] clash_tbl;
  for (genvar gi = 0; gi < NCLS; gi++) begin : g_row
    for (genvar gj = 0; gj < NCLS; gj++) begin : g_col
      assign clash_tbl[gi*NCLS+gj] = (gi == gj);
    end
  end

  logic [IW-1:0] idx;
  logic          in_range;
  logic          clash_hit;
  logic          older_solo;
  logic          younger_solo;

  always_comb begin
    in_range = (int'(a.cls) < NCLS) && (int'(b_cls) < NCLS);
    idx      = IW'(int'(a.cls) * NCLS + int'(b_cls));
    clash_hit = in_range ? clash_tbl[idx] : 1'b1;
  end

  assign older_solo   = a.np | a.mc | a.cs | a_hiword | (a.cls == CL_BR);
  assign younger_solo = b_mc | b_cs;
  assign pair_ok      = a.vld & b_vld & ~clash_hit & ~older_solo & ~younger_solo;
endmodule

// File: rtl/dip_ucode_timer.sv
module dip_ucode_timer #(
  parameter int DELAY = 7,
  localparam int CW   = $clog2(DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          head_mc,
  input  logic          hold,
  output logic          ready,
  output logic [CW-1:0] cnt
);
  assign ready = (cnt == CW'(DELAY));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!head_mc) begin
      cnt <= '0;
    end else if (!ready) begin
      cnt <= cnt + CW'(1);
    end else if (!hold) begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/dual_issue_pair.sv
module dual_issue_pair
  import dip_pkg::*;
#(
  parameter int MC_DELAY = 7,
  localparam int CW      = $clog2(MC_DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s0_vld,
  input  logic [2:0]    s0_cls,
  input  logic          s0_np,
  input  logic          s0_mc,
  input  logic          s0_cs,
  input  logic          s0_hiword,
  input  logic          s1_vld,
  input  logic [2:0]    s1_cls,
  input  logic          s1_mc,
  input  logic          s1_cs,
  input  logic          hold,
  output logic          grant0,
  output logic          grant1,
  output logic [CW-1:0] ucode_wait
);
  head_slot_t older;
  logic       pair_ok;
  logic       mc_ready;
  logic       go0;
  logic       go1;

  assign older = '{vld: s0_vld, cls: s0_cls, np: s0_np, mc: s0_mc, cs: s0_cs};

  dip_pair_rules #(.NCLS(NUM_CLS)) u_rules (
    .a        (older),
    .a_hiword (s0_hiword),
    .b_vld    (s1_vld),
    .b_cls    (s1_cls),
    .b_mc     (s1_mc),
    .b_cs     (s1_cs),
    .pair_ok  (pair_ok)
  );

  dip_ucode_timer #(.DELAY(MC_DELAY)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .head_mc (s0_vld & s0_mc),
    .hold    (hold),
    .ready   (mc_ready),
    .cnt     (ucode_wait)
  );

  assign go0 = s0_vld & ~hold & (~s0_mc | mc_ready);
  assign go1 = go0 & pair_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant0 <= 1'b0;
      grant1 <= 1'b0;
    end else begin
      grant0 <= go0;
      grant1 <= go1;
    end
  end
endmodule

// File: rtl/dip_checker.sv
module dip_checker #(
  parameter int MC_DELAY = 7,
  localparam int CW      = $clog2(MC_DELAY + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          s0_vld,
  input logic [2:0]    s0_cls,
  input logic          s0_mc,
  input logic          s0_hiword,
  input logic          s1_vld,
  input logic [2:0]    s1_cls,
  input logic          s1_mc,
  input logic          s1_cs,
  input logic          hold,
  input logic          grant0,
  input logic          grant1,
  input logic [CW-1:0] ucode_wait
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_pair_needs_head_r3: assert property (@(posedge clk) disable iff (rst)
    grant1 |-> grant0);

  p_same_class_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(s0_vld && s1_vld && s0_cls == s1_cls)) |-> !grant1);

  p_branch_head_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(s0_vld && s0_cls == 3'd2)) |-> !grant1);

  p_cs_young_r5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(s1_cs)) |-> !grant1);

  p_hiword_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(s0_hiword)) |-> !grant1);

  p_mc_full_wait_r7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && grant0 && $past(s0_mc)) |-> ($past(ucode_wait) == CW'(MC_DELAY)));

  p_mc_bound_r7: assert property (@(posedge clk) disable iff (rst)
    ucode_wait <= CW'(MC_DELAY));

  p_mc_young_r8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(s1_mc)) |-> !grant1);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(hold)) |-> !grant0);

  p_empty_head_r10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!s0_vld)) |-> !grant0);
endmodule

bind dual_issue_pair dip_checker #(.MC_DELAY(MC_DELAY)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .s0_vld     (s0_vld),
  .s0_cls     (s0_cls),
  .s0_mc      (s0_mc),
  .s0_hiword  (s0_hiword),
  .s1_vld     (s1_vld),
  .s1_cls     (s1_cls),
  .s1_mc      (s1_mc),
  .s1_cs      (s1_cs),
  .hold       (hold),
  .grant0     (grant0),
  .grant1     (grant1),
  .ucode_wait (ucode_wait)
);

// File: tb/sim_dual_issue_pair.sv
`timescale 1ns/1ps
module sim_dual_issue_pair;
  localparam int MCD = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       s0_vld = 0, s0_np = 0, s0_mc = 0, s0_cs = 0, s0_hiword = 0;
  logic [2:0] s0_cls = 0, s1_cls = 0;
  logic       s1_vld = 0, s1_mc = 0, s1_cs = 0, hold = 0;
  logic       grant0, grant1;
  logic [2:0] ucode_wait;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_issue_pair #(.MC_DELAY(MCD)) u0 (
    .clk(clk), .rst(rst),
    .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_np(s0_np), .s0_mc(s0_mc),
    .s0_cs(s0_cs), .s0_hiword(s0_hiword),
    .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_mc(s1_mc), .s1_cs(s1_cs),
    .hold(hold), .grant0(grant0), .grant1(grant1), .ucode_wait(ucode_wait)
  );

  task automatic chk(input string tag, input logic g0, input logic g1, input int w);
    checks++;
    if (grant0 !== g0 || grant1 !== g1 || int'(ucode_wait) != w) begin
      errors++;
      $display("FAIL %s: got g0=%b g1=%b wait=%0d, expected g0=%b g1=%b wait=%0d",
               tag, grant0, grant1, ucode_wait, g0, g1, w);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    s0_vld = 0; s0_cls = 0; s0_np = 0; s0_mc = 0; s0_cs = 0; s0_hiword = 0;
    s1_vld = 0; s1_cls = 0; s1_mc = 0; s1_cs = 0; hold = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    chk("R1 in reset", 0, 0, 0);
    rst = 0;
    step();
    chk("R1 after reset", 0, 0, 0);

    // pairing sweep: all class pairs times older/younger flags
    for (int c0 = 0; c0 < 5; c0++) begin
      for (int c1 = 0; c1 < 5; c1++) begin
        for (int f = 0; f < 16; f++) begin
          string tag;
          logic exp1;
          clear_in();
          s0_vld = 1; s1_vld = 1;
          s0_cls = 3'(c0); s1_cls = 3'(c1);
          s0_np = f[0]; s0_cs = f[1]; s1_cs = f[2]; s0_hiword = f[3];
          step();
          exp1 = (c0 != c1) && (c0 != 2) && !f[0] && !f[1] && !f[2] && !f[3];
          if (c0 == c1)                tag = "R2 same class";
          else if (c0 == 2 || f[0])    tag = "R4 solo head";
          else if (f[1] || f[2])       tag = "R5 sync";
          else if (f[3])               tag = "R6 upper word";
          else                         tag = "R3 legal pair";
          chk(tag, 1, exp1, 0);
        end
      end
    end

    // branch in younger slot pairs (R4)
    clear_in(); s0_vld = 1; s0_cls = 3'd0; s1_vld = 1; s1_cls = 3'd2;
    step();
    chk("R4 branch young", 1, 1, 0);

    // microcoded head (R7)
    clear_in(); s0_vld = 1; s0_mc = 1; s0_cls = 3'd0; s1_vld = 1; s1_cls = 3'd1;
    for (int k = 1; k <= MCD; k++) begin
      step();
      chk("R7 ucode wait", 0, 0, k);
    end
    step();
    chk("R7 ucode issue", 1, 0, 0);
    clear_in(); s0_vld = 1; s0_cls = 3'd3; s1_vld = 1; s1_cls = 3'd4;
    step();
    chk("R3 after ucode", 1, 1, 0);

    // microcoded younger (R8)
    clear_in(); s0_vld = 1; s0_cls = 3'd1; s1_vld = 1; s1_cls = 3'd0; s1_mc = 1;
    step();
    chk("R8 ucode young", 1, 0, 0);
    step();
    chk("R8 ucode young held", 1, 0, 0);

    // hold (R9)
    clear_in(); s0_vld = 1; s0_cls = 3'd0; s1_vld = 1; s1_cls = 3'd1; hold = 1;
    step();
    chk("R9 hold pair", 0, 0, 0);
    hold = 0;
    step();
    chk("R9 release pair", 1, 1, 0);
    clear_in(); s0_vld = 1; s0_mc = 1; hold = 1;
    for (int k = 1; k <= MCD + 3; k++) begin
      step();
      chk("R9 ucode under hold", 0, 0, (k < MCD) ? k : MCD);
    end
    hold = 0;
    step();
    chk("R9 ucode release", 1, 0, 0);

    // occupancy (R10)
    clear_in(); s0_vld = 1; s0_cls = 3'd4;
    step();
    chk("R10 head only", 1, 0, 0);
    clear_in();
    step();
    chk("R10 empty", 0, 0, 0);

    // reset mid-stream (R1)
    s0_vld = 1; s0_mc = 1;
    step(); step();
    rst = 1;
    step();
    chk("R1 reset clears", 0, 0, 0);
    rst = 0; clear_in();
    step();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule